// File: doc/BRIEF.md
# Shared-Line Interrupt Source Register Block

This block is the interrupt half of a small peripheral that sits on a processor's register bus. It keeps a pending flag, shown in the most significant bit of a status register, and a one-byte data register. When the peripheral's internal event strobe fires, the block captures the event's byte, sets the pending flag and pulls its request output low in the same clock edge. The request is a level. It stays asserted until software services the source.

The request output is open-drain and active low. It is modelled as a pull-down enable: while the enable is high the pin drives 0, and otherwise it floats. Several instances can share one request line, which is low whenever any of them pulls. Software finds the source by reading status registers, because a read of status never releases the line. It releases the line by writing the status register, or by reading or writing the data register.

The register port is plain, with a chip select, an address, read and write strobes and a combinational read-data path. There is no stream interface, so no valid/ready rules apply.

Top module: `irq_src_dev`

## Requirements
- R1: After reset the pending flag is 0, the pull-down enable is low and the data register holds 0.
- R2: An event strobe sets the pending flag, raises the pull-down enable and loads the event byte into the data register, all at the same clock edge.
- R3: Once set, the pending flag and the pull-down enable stay high on every following cycle until a clearing access happens. Further events and accesses that do not clear it leave it high.
- R4: A read at address 0 (status) returns the pending flag in bit 7 and zeros in bits 6..0. The flag and the request are unchanged afterwards.
- R5: A write at address 0 clears the pending flag and releases the request at the next edge, whatever the written value.
- R6: A read at address 1 (data) returns the data register and clears the flag. A write at address 1 loads the written byte and clears the flag.
- R7: If an event and a clearing access fall in the same cycle, the event wins: the flag stays set and the data register takes the event byte.
- R8: Accesses with chip select low, or at addresses 2 and 3, change no state and read as 0. When read and write are both high, the access is treated as a write only and read data is 0.
- R9: The shared request line, taken as the wired-AND of all instances' open-drain outputs, is low exactly when at least one instance has its pull-down enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Chip select for the register port |
| bus_addr | input | 2 | Register address: 0 status, 1 data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data, 0 when no read is selected |
| evt_fire | input | 1 | Internal event strobe |
| evt_byte | input | 8 | Byte captured by an event |
| irq_pull_en | output | 1 | Open-drain enable: 1 pulls the shared active-low request line to 0 |

## Verification
Two instances share one bus and one modelled request line. Directed sequences probe specific cases. Repeated status reads tell a read that clears apart from one that does not. Status writes with all-zero and all-one values show that the written value does not matter. Data reads and data writes are tried separately, each alone and colliding with an event, which tells event priority apart from clear priority. Events on one instance at a time and on both at once tell the wired-AND resolution apart from a single-source line. A long pseudo-random mix of selects, addresses, strobes and events is then compared cycle by cycle with a behavioural model.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  localparam int unsigned BUS_ADDR_W = 2;
  localparam int unsigned BUS_DATA_W = 8;

  typedef enum logic [BUS_ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_DATA   = 2'd1,
    REG_RSVD2  = 2'd2,
    REG_RSVD3  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic st_rd;
    logic st_wr;
    logic dt_rd;
    logic dt_wr;
  } acc_strobes_t;
endpackage

// File: rtl/irq_src_decode.sv
module irq_src_decode
  import irq_src_pkg::*;
#(
  parameter int unsigned ADDR_W = BUS_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output acc_strobes_t      stb,
  output logic              clr_hit
);
  logic is_st, is_dt, do_rd, do_wr;

  always_comb begin
    is_st = (addr == ADDR_W'(REG_STATUS));
    is_dt = (addr == ADDR_W'(REG_DATA));
    do_wr = cs & wr;
    do_rd = cs & rd & ~wr;
    stb.st_rd = do_rd & is_st;
    stb.st_wr = do_wr & is_st;
    stb.dt_rd = do_rd & is_dt;
    stb.dt_wr = do_wr & is_dt;
    clr_hit = stb.st_wr | stb.dt_rd | stb.dt_wr;
  end

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.st_rd, stb.st_wr, stb.dt_rd, stb.dt_wr}));

  assert_deselect_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !clr_hit);
endmodule

// File: rtl/irq_src_flag.sv
module irq_src_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (!rst_n)   pend <= 1'b0;
    else if (evt) pend <= 1'b1;
    else if (clr) pend <= 1'b0;
  end

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend);

  assert_level_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);

  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !pend);
endmodule

// File: rtl/irq_src_data.sv
module irq_src_data #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [DATA_W-1:0] evt_byte,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (evt)   q <= evt_byte;
    else if (wr_en) q <= wdata;
  end

  assert_evt_byte_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (q == $past(evt_byte)));

  assert_data_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !evt) |=> (q == $past(wdata)));
endmodule

// File: rtl/irq_src_dev.sv
module irq_src_dev
  import irq_src_pkg::*;
#(
  parameter int unsigned ADDR_W = BUS_ADDR_W,
  parameter int unsigned DATA_W = BUS_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_fire,
  input  logic [DATA_W-1:0] evt_byte,
  output logic              irq_pull_en
);
  localparam int unsigned FLAG_POS = DATA_W - 1;

  acc_strobes_t      stb;
  logic              clr_hit;
  logic              pend;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] status_word;

  irq_src_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .cs(bus_cs), .addr(bus_addr),
    .rd(bus_rd), .wr(bus_wr), .stb(stb), .clr_hit(clr_hit)
  );

  irq_src_flag u_flag (
    .clk(clk), .rst_n(rst_n), .evt(evt_fire), .clr(clr_hit), .pend(pend)
  );

  irq_src_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .evt(evt_fire), .evt_byte(evt_byte),
    .wr_en(stb.dt_wr), .wdata(bus_wdata), .q(data_q)
  );

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_status_bits
      if (b == FLAG_POS) begin : g_flag
        assign status_word[b] = pend;
      end else begin : g_zero
        assign status_word[b] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (stb.st_rd) bus_rdata = status_word;
    if (stb.dt_rd) bus_rdata = data_q;
  end

  assign irq_pull_en = pend;

  assert_status_shows_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_rd && !bus_wr && bus_addr == ADDR_W'(REG_STATUS))
      |-> (bus_rdata[FLAG_POS] == irq_pull_en));

  assert_status_read_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_rd && !bus_wr && bus_addr == ADDR_W'(REG_STATUS) && irq_pull_en)
      |=> irq_pull_en);

  assert_collision_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fire && bus_cs && bus_wr) |=> irq_pull_en);

  assert_no_read_when_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs |-> (bus_rdata == '0));
endmodule

// File: tb/irq_src_dev_bench.sv
`timescale 1ns/1ps
module irq_src_dev_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       b_rd = 0, b_wr = 0;
  logic [1:0] b_addr = 0;
  logic [7:0] b_wdata = 0;
  logic [1:0] cs = 0, evt = 0;
  logic [7:0] ebyte [2];
  logic [7:0] rdata [2];
  logic [1:0] pull;
  logic       irq_line;

  int checks = 0, errors = 0;
  bit done = 0;

  bit       m_flag [2];
  bit [7:0] m_data [2];

  irq_src_dev u_irq_src_dev (
    .clk(clk), .rst_n(rst_n), .bus_cs(cs[0]), .bus_addr(b_addr),
    .bus_rd(b_rd), .bus_wr(b_wr), .bus_wdata(b_wdata), .bus_rdata(rdata[0]),
    .evt_fire(evt[0]), .evt_byte(ebyte[0]), .irq_pull_en(pull[0])
  );

  irq_src_dev u_irq_src_dev_peer (
    .clk(clk), .rst_n(rst_n), .bus_cs(cs[1]), .bus_addr(b_addr),
    .bus_rd(b_rd), .bus_wr(b_wr), .bus_wdata(b_wdata), .bus_rdata(rdata[1]),
    .evt_fire(evt[1]), .evt_byte(ebyte[1]), .irq_pull_en(pull[1])
  );

  // Open-drain resolution: line is pulled up unless some device pulls it down.
  assign irq_line = !(pull[0] | pull[1]);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_rdata(input int i);
    if (!cs[i] || !b_rd || b_wr) return 0;
    if (b_addr == 2'd0) return m_flag[i] ? 8'h80 : 8'h00;
    if (b_addr == 2'd1) return m_data[i];
    return 0;
  endfunction

  // One bus cycle: inputs are already driven away from the edge; compare, clock, update model.
  task automatic step(input string req);
    #1;
    for (int i = 0; i < 2; i++) begin
      chk(req, $sformatf("rdata[%0d]", i), rdata[i], exp_rdata(i));
      chk(req, $sformatf("pull[%0d]", i), pull[i], m_flag[i]);
    end
    chk("R9", "irq_line", irq_line, !(m_flag[0] | m_flag[1]));
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      bit sel_wr, clr;
      sel_wr = cs[i] && b_wr;
      clr = (sel_wr && b_addr <= 2'd1) || (cs[i] && b_rd && !b_wr && b_addr == 2'd1);
      if (evt[i]) begin
        m_flag[i] = 1;
        m_data[i] = ebyte[i];
      end else begin
        if (sel_wr && b_addr == 2'd1) m_data[i] = b_wdata;
        if (clr) m_flag[i] = 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cs = 0; b_rd = 0; b_wr = 0; evt = 0;
  endtask

  task automatic acc(input int dev, input bit w, input logic [1:0] a,
                     input logic [7:0] d, input string req);
    idle();
    cs[dev] = 1; b_wr = w; b_rd = !w; b_addr = a; b_wdata = d;
    step(req);
    idle();
  endtask

  task automatic fire(input int dev, input logic [7:0] d, input string req);
    idle();
    evt[dev] = 1; ebyte[dev] = d;
    step(req);
    idle();
  endtask

  initial begin
    ebyte[0] = 0; ebyte[1] = 0;
    for (int i = 0; i < 2; i++) begin m_flag[i] = 0; m_data[i] = 0; end
    repeat (3) @(negedge clk);
    @(posedge clk); rst_n = 1; @(negedge clk);
    // R1: reset state, data register reads 0 without clearing anything
    chk("R1", "pull0 after reset", pull[0], 0);
    chk("R1", "line after reset", irq_line, 1);
    acc(0, 0, 2'd1, 8'h00, "R1");
    // R2: event sets flag and captures byte
    fire(0, 8'h5A, "R2");
    chk("R2", "pull0 after event", pull[0], 1);
    // R4: status reads repeat, never clear
    for (int k = 0; k < 3; k++) acc(0, 0, 2'd0, 8'h00, "R4");
    chk("R4", "pull0 after status reads", pull[0], 1);
    // R3: extra event and non-clearing accesses hold the level
    fire(0, 8'hC3, "R3");
    acc(0, 1, 2'd2, 8'hFF, "R3");
    acc(0, 0, 2'd3, 8'h00, "R3");
    for (int k = 0; k < 4; k++) step("R3");
    chk("R3", "pull0 held", pull[0], 1);
    // R5: status write with zero value clears
    acc(0, 1, 2'd0, 8'h00, "R5");
    chk("R5", "pull0 after status write 00", pull[0], 0);
    fire(0, 8'h11, "R5");
    acc(0, 1, 2'd0, 8'hFF, "R5");
    chk("R5", "pull0 after status write FF", pull[0], 0);
    // R6: data read clears, data write loads and clears
    fire(0, 8'h77, "R6");
    acc(0, 0, 2'd1, 8'h00, "R6");
    chk("R6", "pull0 after data read", pull[0], 0);
    fire(0, 8'h22, "R6");
    acc(0, 1, 2'd1, 8'hA5, "R6");
    chk("R6", "pull0 after data write", pull[0], 0);
    acc(0, 0, 2'd1, 8'h00, "R6");
    // R7: event colliding with each clearing access
    idle(); cs[0] = 1; b_wr = 1; b_addr = 2'd0; evt[0] = 1; ebyte[0] = 8'h3C; step("R7"); idle();
    chk("R7", "pull0 after collide status write", pull[0], 1);
    idle(); cs[0] = 1; b_rd = 1; b_addr = 2'd1; evt[0] = 1; ebyte[0] = 8'h96; step("R7"); idle();
    chk("R7", "pull0 after collide data read", pull[0], 1);
    idle(); cs[0] = 1; b_wr = 1; b_addr = 2'd1; b_wdata = 8'h01; evt[0] = 1; ebyte[0] = 8'hE7; step("R7"); idle();
    acc(0, 0, 2'd0, 8'h00, "R7");
    // R8: deselected and reserved accesses, rd+wr together
    idle(); b_wr = 1; b_addr = 2'd0; step("R8"); idle();
    chk("R8", "pull0 after deselected write", pull[0], 1);
    idle(); cs[0] = 1; b_rd = 1; b_wr = 1; b_addr = 2'd0; step("R8"); idle();
    chk("R8", "pull0 after rd+wr status", pull[0], 0);
    // R9: two sources share the line
    fire(1, 8'h44, "R9");
    fire(0, 8'h55, "R9");
    acc(1, 1, 2'd0, 8'h00, "R9");
    chk("R9", "line with dev0 only", irq_line, 0);
    acc(0, 0, 2'd1, 8'h00, "R9");
    chk("R9", "line released", irq_line, 1);
    idle(); evt = 2'b11; ebyte[0] = 8'h0F; ebyte[1] = 8'hF0; step("R9"); idle();
    acc(0, 1, 2'd0, 8'h00, "R9");
    acc(1, 0, 2'd1, 8'h00, "R9");
    // Mixed pseudo-random traffic compared each cycle
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int n = 0; n < 3000; n++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cs = lfsr[1:0]; b_rd = lfsr[2]; b_wr = lfsr[3] & lfsr[9];
        b_addr = lfsr[5:4]; b_wdata = lfsr[15:8];
        evt[0] = lfsr[6] & lfsr[11]; evt[1] = lfsr[7] & lfsr[14];
        ebyte[0] = lfsr[13:6]; ebyte[1] = lfsr[10:3];
        step("R3");
      end
      idle();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule